// File: doc/BRIEF.md
# Power Converter Fault Manager

This block sits beside the PWM engine of a switching converter controller and decides, from digitized comparator flags, whether switching may run. Each flag passes through its own qualifier. Some qualifiers count consecutive low-side or high-side PWM pulses. Others count microsecond ticks while the flag stays high. A pulse counted while the flag is low, or a flag that drops before its timer expires, sends that qualifier back to zero. Qualifiers run only while the converter is switching.

A confirmed fault is sorted into one of four responses. A timed restart pauses switching for a fault-delay period. A hold waits for a separate release flag. A full reset returns to the brown-in startup check. A latch-off keeps switching stopped until the supply falls below its reset level or a line-zero-crossing reset event arrives. A static variant input picks which faults latch. A cause code reports the fault that was acted on.

The long delays (over-power, short-circuit, brown-out and restart) are divided by the `TIME_DIV` parameter so that a bench can shorten them. The short pin timers are never scaled.

Top module: `fault_manager`

## Requirements
- R1: After reset `swEnable`, `restartPending` and `latched` are 0 and `causeCode` is 0. Switching starts on the cycle after the 4th consecutive `pwmLoStb` pulse that sees `brownInFlag` high. A pulse that sees the flag low restarts that count.
- R2: Over-voltage (`ovpFlag`), over-current (`ocpFlag`) and thermal shutdown (`tsdFlag`) are each confirmed when their flag is high on 3 consecutive low-side pulses. A low-side pulse that sees the flag low clears that count.
- R3: Current-sense over-temperature (`csOtpFlag`) is confirmed when the flag is high on 2 consecutive `pwmHiStb` pulses.
- R4: Over-power (`oppFlag`) and short-circuit (`scpFlag`) are confirmed after their flag has been high for `OPP_US/TIME_DIV` (respectively `SCP_US/TIME_DIV`) ticks, with no gap. A single low cycle restarts the count. With a tick on every cycle, `swEnable` is still 1 after L flagged edges and is 0 after L+1.
- R5: Fault-pin over-temperature (`pinOtpFlag`) is confirmed after `PINOTP_US` ticks. Input over-voltage (`iovpFlag`) is confirmed after `IOVP_US` ticks.
- R6: A timed-restart fault raises `restartPending` and drops `swEnable` for `RESTART_US/TIME_DIV`+1 clock cycles when a tick arrives on every cycle. Switching then resumes with no startup check. At most one of `swEnable`, `restartPending` and `latched` is high.
- R7: A hold response (input over-voltage always, and fault-pin over-temperature in variant 0) keeps switching off. It ignores brown-in pulses until the matching release flag (`iovpRelease` or `pinOtpRelease`) is high, and then returns to the startup check.
- R8: `variantSel` encodes the variant as 0 = all auto-recovery, 1 = wide latch and 2 = narrow latch; 3 behaves as 0. Variant 1 latches over-voltage, both over-temperature sources, over-current, over-power and short-circuit. Variant 2 latches only over-voltage and fault-pin over-temperature. All other faults use a timed restart.
- R9: While latched, switching stays off and brown-in pulses are ignored until `lineZeroRst` or `supplyRst` is high. Either one returns the block to the startup check.
- R10: Brown-out is confirmed when `brownOutFlag` has been held for `BO_US/TIME_DIV` ticks and then seen on 3 more consecutive low-side pulses. It causes a full reset to the startup check, and so does a confirmed thermal shutdown.
- R11: `causeCode` is 1 over-voltage, 2 fault-pin over-temperature, 3 over-current, 4 over-power, 5 short-circuit, 6 current-sense over-temperature, 7 input over-voltage, 8 thermal shutdown, 9 brown-out. Among faults confirmed together the response ranks latch, then hold, then full reset, then timed restart. A tie goes to the lower code.
- R12: `supplyRst` moves the block from any state to the startup check on the next edge and clears `causeCode` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| usTick | input | 1 | One-cycle strobe every microsecond |
| pwmLoStb | input | 1 | One-cycle strobe per low-side PWM pulse |
| pwmHiStb | input | 1 | One-cycle strobe per high-side PWM pulse |
| variantSel | input | 2 | Static response-variant select |
| ovpFlag | input | 1 | Output over-voltage comparator |
| pinOtpFlag | input | 1 | Fault-pin over-temperature comparator |
| pinOtpRelease | input | 1 | Fault-pin temperature back below its hysteresis point |
| ocpFlag | input | 1 | Over-current comparator |
| oppFlag | input | 1 | Over-power comparator |
| scpFlag | input | 1 | Short-circuit condition |
| csOtpFlag | input | 1 | Current-sense-path over-temperature |
| iovpFlag | input | 1 | Input over-voltage comparator |
| iovpRelease | input | 1 | Input voltage back below its hysteresis point |
| tsdFlag | input | 1 | Junction thermal shutdown |
| brownInFlag | input | 1 | Line high enough to start |
| brownOutFlag | input | 1 | Line too low to run |
| supplyRst | input | 1 | Supply fell below its reset level |
| lineZeroRst | input | 1 | Line-zero-crossing reset event |
| swEnable | output | 1 | Switching allowed |
| restartPending | output | 1 | Timed restart delay running |
| latched | output | 1 | Latched off |
| causeCode | output | 4 | Code of the fault acted on last |

## Verification
Timer boundaries are probed cycle by cycle. A timer that is off by one edge, or that does not restart after a one-cycle gap, trips early or late, and the restart window ends up one cycle longer or shorter than expected. Pulse counters are broken up by one unflagged pulse. A counter that only counts flagged pulses would confirm over-current or start up one pulse too soon. Simultaneous faults across two response classes show whether the priority encoder ranks by response class or only by code. A latched or held state is fed brown-in pulses to show that it does not slip back into startup early. Variant 3 and a supply reset during the restart delay cover the decode default and the global reset path.

// File: rtl/fm_pkg.sv
package fm_pkg;

  localparam int NFAULT     = 9;
  localparam int FID_OVP    = 0;
  localparam int FID_PINOTP = 1;
  localparam int FID_OCP    = 2;
  localparam int FID_OPP    = 3;
  localparam int FID_SCP    = 4;
  localparam int FID_CSOTP  = 5;
  localparam int FID_IOVP   = 6;
  localparam int FID_TSD    = 7;
  localparam int FID_BO     = 8;

  typedef enum logic [1:0] {
    VAR_ALLAUTO     = 2'd0,
    VAR_WIDELATCH   = 2'd1,
    VAR_NARROWLATCH = 2'd2
  } variant_e;

  // Higher value wins the priority encoder.
  typedef enum logic [1:0] {
    RANK_RESTART = 2'd0,
    RANK_RESET   = 2'd1,
    RANK_HOLD    = 2'd2,
    RANK_LATCH   = 2'd3
  } rank_e;

  typedef enum logic [2:0] {
    ST_START,
    ST_RUN,
    ST_RESTART,
    ST_HOLD,
    ST_LATCH
  } state_e;

  typedef struct packed {
    logic clrQual;     // hold every fault qualifier at zero
    logic runBrownIn;  // brown-in counter may advance
    logic runRestart;  // fault-delay timer may advance
  } fmStrobes_t;

  function automatic variant_e decodeVariant(input logic [1:0] sel);
    case (sel)
      2'd1:    return VAR_WIDELATCH;
      2'd2:    return VAR_NARROWLATCH;
      default: return VAR_ALLAUTO;
    endcase
  endfunction

  function automatic rank_e rankOf(input variant_e v, input int idx);
    case (idx)
      FID_OVP:    return (v == VAR_ALLAUTO) ? RANK_RESTART : RANK_LATCH;
      FID_PINOTP: return (v == VAR_ALLAUTO) ? RANK_HOLD : RANK_LATCH;
      FID_OCP, FID_OPP, FID_SCP, FID_CSOTP:
                  return (v == VAR_WIDELATCH) ? RANK_LATCH : RANK_RESTART;
      FID_IOVP:   return RANK_HOLD;
      default:    return RANK_RESET;
    endcase
  endfunction

endpackage

// File: rtl/fm_pulse_qual.sv
module fm_pulse_qual #(
  parameter int COUNT = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic stb,
  input  logic flag,
  output logic hit
);
  localparam int W = $clog2(COUNT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   cnt <= '0;
    else if (clr)                cnt <= '0;
    else if (stb) begin
      if (!flag)                 cnt <= '0;
      else if (cnt != W'(COUNT)) cnt <= cnt + 1'b1;
    end
  end

  assign hit = (cnt == W'(COUNT));

  assert_pulse_bound_R2: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= W'(COUNT));

  // an unflagged pulse leaves nothing confirmed
  assert_pulse_miss_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb && !flag) |=> !hit);

endmodule

// File: rtl/fm_timer_qual.sv
module fm_timer_qual #(
  parameter int LIMIT = 160
) (
  input  logic clk,
  input  logic rstN,
  input  logic clr,
  input  logic tick,
  input  logic flag,
  output logic hit
);
  localparam int W = $clog2(LIMIT + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            cnt <= '0;
    else if (clr || !flag)                cnt <= '0;
    else if (tick && cnt != W'(LIMIT))    cnt <= cnt + 1'b1;
  end

  assign hit = flag && (cnt == W'(LIMIT));

  assert_timer_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= W'(LIMIT));

  assert_timer_drop_R4: assert property (@(posedge clk) disable iff (!rstN)
    !flag |=> (cnt == '0));

endmodule

// File: rtl/fm_qualify.sv
module fm_qualify
  import fm_pkg::*;
#(
  parameter int OPP_LIM     = 160000,
  parameter int SCP_LIM     = 160000,
  parameter int BO_LIM      = 60000,
  parameter int RESTART_LIM = 1500000,
  parameter int PINOTP_LIM  = 50,
  parameter int IOVP_LIM    = 750,
  parameter int LO_PULSES   = 3,
  parameter int HI_PULSES   = 2,
  parameter int BI_PULSES   = 4,
  parameter int BO_PULSES   = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usTick,
  input  logic              pwmLoStb,
  input  logic              pwmHiStb,
  input  fmStrobes_t        strobes,
  input  logic              ovpFlag,
  input  logic              pinOtpFlag,
  input  logic              ocpFlag,
  input  logic              oppFlag,
  input  logic              scpFlag,
  input  logic              csOtpFlag,
  input  logic              iovpFlag,
  input  logic              tsdFlag,
  input  logic              brownInFlag,
  input  logic              brownOutFlag,
  output logic [NFAULT-1:0] confirmed,
  output logic              brownInOk,
  output logic              restartDone
);
  localparam int NLO = 3;

  logic [NLO-1:0] loFlags;
  logic [NLO-1:0] loHit;
  logic           boArmed;
  logic           boHit;
  logic           oppHit, scpHit, pinOtpHit, iovpHit, csOtpHit;

  assign loFlags = {tsdFlag, ocpFlag, ovpFlag};

  for (genvar g = 0; g < NLO; g++) begin : gLo
    fm_pulse_qual #(.COUNT(LO_PULSES)) uLo (
      .clk(clk), .rstN(rstN), .clr(strobes.clrQual),
      .stb(pwmLoStb), .flag(loFlags[g]), .hit(loHit[g]));
  end

  fm_pulse_qual #(.COUNT(HI_PULSES)) uCsOtp (
    .clk(clk), .rstN(rstN), .clr(strobes.clrQual),
    .stb(pwmHiStb), .flag(csOtpFlag), .hit(csOtpHit));

  fm_timer_qual #(.LIMIT(OPP_LIM)) uOpp (
    .clk(clk), .rstN(rstN), .clr(strobes.clrQual),
    .tick(usTick), .flag(oppFlag), .hit(oppHit));

  fm_timer_qual #(.LIMIT(SCP_LIM)) uScp (
    .clk(clk), .rstN(rstN), .clr(strobes.clrQual),
    .tick(usTick), .flag(scpFlag), .hit(scpHit));

  fm_timer_qual #(.LIMIT(PINOTP_LIM)) uPinOtp (
    .clk(clk), .rstN(rstN), .clr(strobes.clrQual),
    .tick(usTick), .flag(pinOtpFlag), .hit(pinOtpHit));

  fm_timer_qual #(.LIMIT(IOVP_LIM)) uIovp (
    .clk(clk), .rstN(rstN), .clr(strobes.clrQual),
    .tick(usTick), .flag(iovpFlag), .hit(iovpHit));

  // brown-out: long hold time arms a short pulse confirmation
  fm_timer_qual #(.LIMIT(BO_LIM)) uBoHold (
    .clk(clk), .rstN(rstN), .clr(strobes.clrQual),
    .tick(usTick), .flag(brownOutFlag), .hit(boArmed));

  fm_pulse_qual #(.COUNT(BO_PULSES)) uBoPulse (
    .clk(clk), .rstN(rstN), .clr(strobes.clrQual || !brownOutFlag),
    .stb(pwmLoStb), .flag(boArmed), .hit(boHit));

  fm_pulse_qual #(.COUNT(BI_PULSES)) uBrownIn (
    .clk(clk), .rstN(rstN), .clr(!strobes.runBrownIn),
    .stb(pwmLoStb), .flag(brownInFlag), .hit(brownInOk));

  fm_timer_qual #(.LIMIT(RESTART_LIM)) uRestart (
    .clk(clk), .rstN(rstN), .clr(1'b0),
    .tick(usTick), .flag(strobes.runRestart), .hit(restartDone));

  always_comb begin
    confirmed             = '0;
    confirmed[FID_OVP]    = loHit[0];
    confirmed[FID_OCP]    = loHit[1];
    confirmed[FID_TSD]    = loHit[2];
    confirmed[FID_PINOTP] = pinOtpHit;
    confirmed[FID_OPP]    = oppHit;
    confirmed[FID_SCP]    = scpHit;
    confirmed[FID_CSOTP]  = csOtpHit;
    confirmed[FID_IOVP]   = iovpHit;
    confirmed[FID_BO]     = boHit;
  end

endmodule

// File: rtl/fm_control.sv
module fm_control
  import fm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        variantSel,
  input  logic [NFAULT-1:0] confirmed,
  input  logic              brownInOk,
  input  logic              restartDone,
  input  logic              pinOtpRelease,
  input  logic              iovpRelease,
  input  logic              supplyRst,
  input  logic              lineZeroRst,
  output fmStrobes_t        strobes,
  output logic              swEnable,
  output logic              restartPending,
  output logic              latched,
  output logic [3:0]        causeCode
);
  state_e   state;
  logic     holdOnIovp;
  variant_e variant;
  rank_e    bestRank;
  int       bestIdx;
  logic     anyHit;

  assign variant = decodeVariant(variantSel);

  // class rank first, lower index breaks ties
  always_comb begin
    anyHit   = 1'b0;
    bestRank = RANK_RESTART;
    bestIdx  = 0;
    for (int i = 0; i < NFAULT; i++) begin
      if (confirmed[i] && (!anyHit || rankOf(variant, i) > bestRank)) begin
        anyHit   = 1'b1;
        bestRank = rankOf(variant, i);
        bestIdx  = i;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_START;
      causeCode  <= '0;
      holdOnIovp <= 1'b0;
    end else if (supplyRst) begin
      state      <= ST_START;
      causeCode  <= '0;
    end else begin
      case (state)
        ST_START:   if (brownInOk) state <= ST_RUN;
        ST_RUN: begin
          if (anyHit) begin
            causeCode  <= 4'(bestIdx + 1);
            holdOnIovp <= (bestIdx == FID_IOVP);
            case (bestRank)
              RANK_LATCH: state <= ST_LATCH;
              RANK_HOLD:  state <= ST_HOLD;
              RANK_RESET: state <= ST_START;
              default:    state <= ST_RESTART;
            endcase
          end
        end
        ST_RESTART: if (restartDone) state <= ST_RUN;
        ST_HOLD:    if (holdOnIovp ? iovpRelease : pinOtpRelease) state <= ST_START;
        ST_LATCH:   if (lineZeroRst) state <= ST_START;
        default:    state <= ST_START;
      endcase
    end
  end

  assign strobes.clrQual    = (state != ST_RUN);
  assign strobes.runBrownIn = (state == ST_START);
  assign strobes.runRestart = (state == ST_RESTART);

  assign swEnable       = (state == ST_RUN);
  assign restartPending = (state == ST_RESTART);
  assign latched        = (state == ST_LATCH);

  assert_status_onehot_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({swEnable, restartPending, latched}));

  assert_restart_resume_R6: assert property (@(posedge clk) disable iff (!rstN)
    (restartPending && restartDone && !supplyRst) |=> swEnable);

  assert_latch_holds_R9: assert property (@(posedge clk) disable iff (!rstN)
    (latched && !lineZeroRst && !supplyRst) |=> latched);

  assert_supply_clears_R12: assert property (@(posedge clk) disable iff (!rstN)
    supplyRst |=> (!swEnable && !latched && !restartPending && causeCode == 4'd0));

  assert_enable_needs_cause_R11: assert property (@(posedge clk) disable iff (!rstN)
    (swEnable && anyHit && !supplyRst) |=> (causeCode != 4'd0));

endmodule

// File: rtl/fault_manager.sv
module fault_manager
  import fm_pkg::*;
#(
  parameter int OPP_US     = 160000,
  parameter int SCP_US     = 160000,
  parameter int BO_US      = 60000,
  parameter int RESTART_US = 1500000,
  parameter int PINOTP_US  = 50,
  parameter int IOVP_US    = 750,
  parameter int TIME_DIV   = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       usTick,
  input  logic       pwmLoStb,
  input  logic       pwmHiStb,
  input  logic [1:0] variantSel,
  input  logic       ovpFlag,
  input  logic       pinOtpFlag,
  input  logic       pinOtpRelease,
  input  logic       ocpFlag,
  input  logic       oppFlag,
  input  logic       scpFlag,
  input  logic       csOtpFlag,
  input  logic       iovpFlag,
  input  logic       iovpRelease,
  input  logic       tsdFlag,
  input  logic       brownInFlag,
  input  logic       brownOutFlag,
  input  logic       supplyRst,
  input  logic       lineZeroRst,
  output logic       swEnable,
  output logic       restartPending,
  output logic       latched,
  output logic [3:0] causeCode
);
  localparam int OPP_LIM     = (OPP_US / TIME_DIV < 1) ? 1 : OPP_US / TIME_DIV;
  localparam int SCP_LIM     = (SCP_US / TIME_DIV < 1) ? 1 : SCP_US / TIME_DIV;
  localparam int BO_LIM      = (BO_US / TIME_DIV < 1) ? 1 : BO_US / TIME_DIV;
  localparam int RESTART_LIM = (RESTART_US / TIME_DIV < 1) ? 1 : RESTART_US / TIME_DIV;

  fmStrobes_t        strobes;
  logic [NFAULT-1:0] confirmed;
  logic              brownInOk;
  logic              restartDone;

  fm_qualify #(
    .OPP_LIM(OPP_LIM), .SCP_LIM(SCP_LIM), .BO_LIM(BO_LIM),
    .RESTART_LIM(RESTART_LIM), .PINOTP_LIM(PINOTP_US), .IOVP_LIM(IOVP_US),
    .LO_PULSES(3), .HI_PULSES(2), .BI_PULSES(4), .BO_PULSES(3)
  ) uQualify (
    .clk(clk), .rstN(rstN), .usTick(usTick),
    .pwmLoStb(pwmLoStb), .pwmHiStb(pwmHiStb), .strobes(strobes),
    .ovpFlag(ovpFlag), .pinOtpFlag(pinOtpFlag), .ocpFlag(ocpFlag),
    .oppFlag(oppFlag), .scpFlag(scpFlag), .csOtpFlag(csOtpFlag),
    .iovpFlag(iovpFlag), .tsdFlag(tsdFlag),
    .brownInFlag(brownInFlag), .brownOutFlag(brownOutFlag),
    .confirmed(confirmed), .brownInOk(brownInOk), .restartDone(restartDone));

  fm_control uControl (
    .clk(clk), .rstN(rstN), .variantSel(variantSel),
    .confirmed(confirmed), .brownInOk(brownInOk), .restartDone(restartDone),
    .pinOtpRelease(pinOtpRelease), .iovpRelease(iovpRelease),
    .supplyRst(supplyRst), .lineZeroRst(lineZeroRst),
    .strobes(strobes), .swEnable(swEnable), .restartPending(restartPending),
    .latched(latched), .causeCode(causeCode));

endmodule

// File: tb/fault_manager_test.sv
module fault_manager_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 1000;
  localparam int OPP_L      = 160;
  localparam int BO_L       = 60;
  localparam int RST_L      = 1500;
  localparam int PIN_L      = 50;
  localparam int IOVP_L     = 750;

  // response classes: 0 timed restart, 1 latch, 2 hold, 3 full reset
  localparam int NVEC = 23;
  localparam logic [7:0] VEC [NVEC] = '{
    {2'd0, 4'd1, 2'd0}, {2'd0, 4'd2, 2'd2}, {2'd0, 4'd3, 2'd0}, {2'd0, 4'd4, 2'd0},
    {2'd0, 4'd5, 2'd0}, {2'd0, 4'd6, 2'd0}, {2'd0, 4'd7, 2'd2}, {2'd0, 4'd8, 2'd3},
    {2'd0, 4'd9, 2'd3},
    {2'd1, 4'd1, 2'd1}, {2'd1, 4'd2, 2'd1}, {2'd1, 4'd3, 2'd1}, {2'd1, 4'd4, 2'd1},
    {2'd1, 4'd5, 2'd1}, {2'd1, 4'd6, 2'd1}, {2'd1, 4'd7, 2'd2}, {2'd1, 4'd8, 2'd3},
    {2'd2, 4'd1, 2'd1}, {2'd2, 4'd2, 2'd1}, {2'd2, 4'd3, 2'd0}, {2'd2, 4'd4, 2'd0},
    {2'd2, 4'd6, 2'd0}, {2'd2, 4'd7, 2'd2}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic usTick = 1'b1;
  logic pwmLoStb = 1'b0, pwmHiStb = 1'b0;
  logic [1:0] variantSel = 2'd0;
  logic ovpFlag = 0, pinOtpFlag = 0, pinOtpRelease = 0, ocpFlag = 0, oppFlag = 0;
  logic scpFlag = 0, csOtpFlag = 0, iovpFlag = 0, iovpRelease = 0, tsdFlag = 0;
  logic brownInFlag = 0, brownOutFlag = 0, supplyRst = 0, lineZeroRst = 0;
  logic swEnable, restartPending, latched;
  logic [3:0] causeCode;

  int vecCount = 0;
  int missCount = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fault_manager #(.TIME_DIV(DIV)) uut (
    .clk(clk), .rstN(rstN), .usTick(usTick),
    .pwmLoStb(pwmLoStb), .pwmHiStb(pwmHiStb), .variantSel(variantSel),
    .ovpFlag(ovpFlag), .pinOtpFlag(pinOtpFlag), .pinOtpRelease(pinOtpRelease),
    .ocpFlag(ocpFlag), .oppFlag(oppFlag), .scpFlag(scpFlag),
    .csOtpFlag(csOtpFlag), .iovpFlag(iovpFlag), .iovpRelease(iovpRelease),
    .tsdFlag(tsdFlag), .brownInFlag(brownInFlag), .brownOutFlag(brownOutFlag),
    .supplyRst(supplyRst), .lineZeroRst(lineZeroRst),
    .swEnable(swEnable), .restartPending(restartPending),
    .latched(latched), .causeCode(causeCode));

  task automatic check(input string req, input int act, input int exp);
    vecCount++;
    if (act !== exp) begin
      missCount++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic loPulse();
    @(negedge clk) pwmLoStb = 1'b1;
    @(negedge clk) pwmLoStb = 1'b0;
  endtask

  task automatic hiPulse();
    @(negedge clk) pwmHiStb = 1'b1;
    @(negedge clk) pwmHiStb = 1'b0;
  endtask

  task automatic clearFlags();
    ovpFlag = 0; pinOtpFlag = 0; ocpFlag = 0; oppFlag = 0; scpFlag = 0;
    csOtpFlag = 0; iovpFlag = 0; tsdFlag = 0; brownOutFlag = 0;
    pinOtpRelease = 0; iovpRelease = 0; supplyRst = 0; lineZeroRst = 0;
  endtask

  task automatic doReset(input logic [1:0] v);
    @(negedge clk);
    rstN = 1'b0;
    clearFlags();
    brownInFlag = 0;
    variantSel = v;
    idle(3);
    rstN = 1'b1;
    idle(1);
  endtask

  task automatic startup();
    brownInFlag = 1'b1;
    repeat (4) loPulse();
    idle(1);
    brownInFlag = 1'b0;
  endtask

  task automatic setFlag(input int code, input logic val);
    case (code)
      1: ovpFlag = val;
      2: pinOtpFlag = val;
      3: ocpFlag = val;
      4: oppFlag = val;
      5: scpFlag = val;
      6: csOtpFlag = val;
      7: iovpFlag = val;
      8: tsdFlag = val;
      default: brownOutFlag = val;
    endcase
  endtask

  // drive a fault long enough to confirm it, then withdraw it
  task automatic applyFault(input int code);
    setFlag(code, 1'b1);
    case (code)
      1, 3, 8: repeat (3) loPulse();
      6:       repeat (2) hiPulse();
      4, 5:    idle(OPP_L + 1);
      2:       idle(PIN_L + 1);
      7:       idle(IOVP_L + 1);
      default: begin idle(BO_L + 2); repeat (3) loPulse(); end
    endcase
    idle(1);
    setFlag(code, 1'b0);
    idle(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      missCount++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    idle(2);
    check("R1 reset swEnable", swEnable, 0);
    check("R1 reset restartPending", restartPending, 0);
    check("R1 reset latched", latched, 0);
    check("R1 reset causeCode", causeCode, 0);
    rstN = 1'b1;

    // variant table walk (R8), with class-specific follow-up
    for (int i = 0; i < NVEC; i++) begin
      automatic logic [1:0] v = VEC[i][7:6];
      automatic int code = int'(VEC[i][5:2]);
      automatic int cls = int'(VEC[i][1:0]);
      doReset(v);
      startup();
      check("R1 startup enable", swEnable, 1);
      applyFault(code);
      check("R11 cause code", causeCode, code);
      check("R8 restart class", restartPending, (cls == 0) ? 1 : 0);
      check("R8 latch class", latched, (cls == 1) ? 1 : 0);
      check("R8 switching off", swEnable, 0);
      if (cls == 2) begin
        startup();
        check("R7 hold ignores brown-in", swEnable, 0);
        if (code == 7) iovpRelease = 1'b1; else pinOtpRelease = 1'b1;
        idle(1);
        iovpRelease = 1'b0; pinOtpRelease = 1'b0;
        startup();
        check("R7 release then startup", swEnable, 1);
      end else if (cls == 3) begin
        startup();
        check("R10 full reset needs brown-in", swEnable, 1);
      end else if (cls == 1) begin
        lineZeroRst = 1'b1; idle(1); lineZeroRst = 1'b0;
        check("R9 line-zero clears latch", latched, 0);
      end
    end

    // R1 brown-in count broken by an unflagged pulse
    doReset(2'd0);
    brownInFlag = 1'b1;
    repeat (3) loPulse();
    brownInFlag = 1'b0; loPulse(); brownInFlag = 1'b1;
    repeat (3) loPulse();
    idle(1);
    check("R1 brown-in gap restarts count", swEnable, 0);
    loPulse(); idle(1);
    brownInFlag = 1'b0;
    check("R1 fourth consecutive pulse starts", swEnable, 1);

    // R2 over-current count broken by an unflagged pulse
    ocpFlag = 1'b1; repeat (2) loPulse();
    ocpFlag = 1'b0; loPulse(); ocpFlag = 1'b1;
    repeat (2) loPulse(); idle(1);
    check("R2 pulse gap restarts count", swEnable, 1);
    loPulse(); idle(1);
    ocpFlag = 1'b0;
    check("R2 third pulse confirms", restartPending, 1);

    // R4 over-power exact boundary and gap, then R6 restart length
    doReset(2'd0);
    startup();
    oppFlag = 1'b1; idle(OPP_L - 1);
    oppFlag = 1'b0; idle(1);
    oppFlag = 1'b1; idle(OPP_L);
    check("R4 still running at limit edge", swEnable, 1);
    idle(1);
    check("R4 confirmed one edge later", restartPending, 1);
    oppFlag = 1'b0;
    begin
      int n = 1;
      while (restartPending && n < 5000) begin
        idle(1);
        if (restartPending) n++;
      end
      check("R6 restart window cycles", n, RST_L + 1);
    end
    check("R6 resumes without startup", swEnable, 1);

    // R3 current-sense over-temperature needs two high-side pulses
    csOtpFlag = 1'b1; hiPulse(); idle(1);
    check("R3 one high pulse not enough", swEnable, 1);
    hiPulse(); idle(1);
    csOtpFlag = 1'b0;
    check("R3 second high pulse confirms", causeCode, 6);

    // R9 latch ignores brown-in, cleared by lineZeroRst; R12 by supplyRst
    doReset(2'd1);
    startup();
    applyFault(3);
    idle(50);
    startup();
    check("R9 latch holds through brown-in", latched, 1);
    check("R9 latch keeps switching off", swEnable, 0);
    lineZeroRst = 1'b1; idle(1); lineZeroRst = 1'b0;
    startup();
    check("R9 restart after line-zero", swEnable, 1);
    applyFault(1);
    check("R9 latched again", latched, 1);
    supplyRst = 1'b1; idle(1); supplyRst = 1'b0;
    check("R12 supply reset clears latch", latched, 0);
    check("R12 supply reset clears cause", causeCode, 0);

    // R11 priority: latch beats restart in variant 2
    doReset(2'd2);
    startup();
    ovpFlag = 1'b1; ocpFlag = 1'b1;
    repeat (3) loPulse(); idle(1);
    ovpFlag = 1'b0; ocpFlag = 1'b0;
    check("R11 latch outranks restart", latched, 1);
    check("R11 latch cause", causeCode, 1);

    // R11 priority: full reset beats restart even with a higher code
    doReset(2'd0);
    startup();
    ocpFlag = 1'b1; tsdFlag = 1'b1;
    repeat (3) loPulse(); idle(1);
    ocpFlag = 1'b0; tsdFlag = 1'b0;
    check("R11 reset outranks restart", restartPending, 0);
    check("R11 reset cause", causeCode, 8);

    // R12 supply reset during restart delay
    startup();
    applyFault(3);
    check("R12 restart running", restartPending, 1);
    supplyRst = 1'b1; idle(1); supplyRst = 1'b0;
    check("R12 restart aborted", restartPending, 0);
    check("R12 cause cleared", causeCode, 0);

    // R8 variant 3 decodes as variant 0
    doReset(2'd3);
    startup();
    applyFault(1);
    check("R8 variant 3 restarts on over-voltage", restartPending, 1);

    // R5 fault-pin over-temperature boundary (variant 0 hold)
    doReset(2'd0);
    startup();
    pinOtpFlag = 1'b1; idle(PIN_L);
    check("R5 pin timer at limit edge", swEnable, 1);
    idle(1);
    pinOtpFlag = 1'b0;
    check("R5 pin timer confirms", causeCode, 2);

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, missCount);
    $finish;
  end

endmodule